// File: doc/BRIEF.md
# Alarm-Driven Power Enable with Wakeup Pins

This block owns a power-enable output for an external regulator. It compares a second time-of-day alarm against the running BCD calendar once per second. When every field agrees and alarm power control is switched on, it drives the power-enable output to its off level. Power comes back when an enabled external wakeup pin becomes active or when the primary alarm fires. The calendar counter that produces the time and the one-second tick lives outside the block.

Each wakeup pin passes through a synchronizer. It is then qualified by its own enable bit and its own polarity bit, both held in a 32-bit power control word. The second alarm has a sticky event flag that is cleared by writing 1, and an interrupt-enable input that gates the flag onto an interrupt line. The power control word can be read back, so that software sees what it wrote.

Top module: `rtc_pwr_wake_ctrl`

## Requirements
- R1: After reset `pwr_en` is 1, `alm2_flag` and `alm2_irq` are 0, and `cfg_rdata` reads 0x000000F0, so all four pins default to active low and are disabled.
- R2: A `cfg_wr` pulse loads `cfg_wdata` into the control word at the next edge. Only bits 3:0 (pin enables), 7:4 (pin polarities) and 16 (alarm power control) are stored. Every other bit reads back as 0.
- R3: When `sec_tick` is high and all six BCD fields of `now_bcd` equal `alm2_bcd`, the alarm hits. `alm2_flag` is then 1 two edges after the tick edge. Both buses are packed as {year, month, day, hour, minute, second}, with 8 bits per field and the second field in bits 7:0.
- R4: No hit occurs without `sec_tick`, or when any single field differs.
- R5: A pulse on `alm2_clr` clears `alm2_flag`. If a hit and a clear arrive in the same cycle, the flag stays set.
- R6: `alm2_irq` is high exactly while both `alm2_flag` and `alm2_ie` are high.
- R7: An alarm hit with control bit 16 set drives `pwr_en` to 0 one edge after the hit is registered. With bit 16 clear, a hit leaves `pwr_en` at 1.
- R8: Wakeup pin n is enabled by control bit n. If control bit 4+n is 1, the pin is active low. A falling edge on an enabled active-low pin sets `pwr_en` to 1 at the third clock edge after the pin changes.
- R9: If control bit 4+n is 0, the pin is active high, and a rising edge restores `pwr_en` with the same latency.
- R10: Only a transition into the active level wakes the block. A pin with its enable bit clear, or a pin held at its active level, leaves `pwr_en` at 0.
- R11: A one-cycle `alm1_fire` pulse sets `pwr_en` to 1 at the next edge.
- R12: If a power-on cause and a power-off hit arrive in the same cycle, power-on wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the power control word |
| cfg_wdata | input | 32 | Value written to the power control word |
| cfg_rdata | output | 32 | Current power control word |
| sec_tick | input | 1 | One-cycle pulse once per second from the calendar |
| now_bcd | input | 48 | Current BCD time {yr,mo,dy,hr,mn,sc} |
| alm2_bcd | input | 48 | Second alarm compare value, same packing |
| alm2_ie | input | 1 | Interrupt enable for the second alarm |
| alm2_clr | input | 1 | Write-1 clear of the second alarm flag |
| alm1_fire | input | 1 | Primary alarm event pulse |
| wake_pin | input | 4 | External wakeup pins (asynchronous) |
| pwr_en | output | 1 | Power-enable output, 1 means on |
| alm2_flag | output | 1 | Sticky second alarm event flag |
| alm2_irq | output | 1 | Second alarm interrupt |

## Verification
A wrong synchronizer depth or a stale copy of the active level shows up first as `pwr_en` rising on the wrong edge. The bench therefore samples both the cycle before and the cycle of the expected change. A corrupted polarity or enable bit shows up within three edges, either as a missing wake or as a spurious one. Tests that hold a pin level or change polarity expose this. A field compare fault shows up two edges after a tick, as a flag that is set when it should be clear or clear when it should be set. Each vector in the table aims at one such field.

// File: rtl/rpw_pkg.sv
package rpw_pkg;
   localparam int CFG_W     = 32;
   localparam int WAKE_MAX  = 4;
   localparam int POL_LSB   = 4;
   localparam int PCTL_BIT  = 16;
   localparam logic [CFG_W-1:0] PCTL_MASK = CFG_W'(1) << PCTL_BIT;

   typedef enum logic {PWR_OFF = 1'b0, PWR_ON = 1'b1} pwr_state_e;

   function automatic logic [CFG_W-1:0] en_mask(input int n);
      logic [CFG_W-1:0] m;
      m = '0;
      for (int k = 0; k < n; k++) m[k] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/rpw_cfg_reg.sv
module rpw_cfg_reg
   import rpw_pkg::*;
#(
   parameter int NUM_WAKE = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_i,
   input  logic [CFG_W-1:0]    wdata_i,
   output logic [CFG_W-1:0]    cfg_o,
   output logic [NUM_WAKE-1:0] en_o,
   output logic [NUM_WAKE-1:0] pol_o,
   output logic                pctl_o
);
   localparam logic [CFG_W-1:0] EN_M  = en_mask(NUM_WAKE);
   localparam logic [CFG_W-1:0] POL_M = EN_M << POL_LSB;
   localparam logic [CFG_W-1:0] WR_M  = EN_M | POL_M | PCTL_MASK;

   logic [CFG_W-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cfg_q <= POL_M;
      else if (wr_i) cfg_q <= wdata_i & WR_M;
   end

   assign cfg_o  = cfg_q;
   assign en_o   = cfg_q[NUM_WAKE-1:0];
   assign pol_o  = cfg_q[POL_LSB +: NUM_WAKE];
   assign pctl_o = cfg_q[PCTL_BIT];

   // R2
   cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (cfg_q == ($past(wdata_i) & WR_M)));
endmodule

// File: rtl/rpw_alarm_cmp.sv
module rpw_alarm_cmp #(
   parameter int FLD_W = 8,
   parameter int N_FLD = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   tick_i,
   input  logic [FLD_W*N_FLD-1:0] now_i,
   input  logic [FLD_W*N_FLD-1:0] alm_i,
   output logic                   hit_o
);
   logic [N_FLD-1:0] fld_eq;
   logic             hit_q;

   genvar f;
   for (f = 0; f < N_FLD; f++) begin : g_fld
      assign fld_eq[f] = (now_i[f*FLD_W +: FLD_W] == alm_i[f*FLD_W +: FLD_W]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hit_q <= 1'b0;
      else        hit_q <= tick_i & (&fld_eq);
   end

   assign hit_o = hit_q;

   // R4
   hit_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit_q |-> $past(tick_i));
endmodule

// File: rtl/rpw_wake_det.sv
module rpw_wake_det #(
   parameter int NUM_WAKE    = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_WAKE-1:0] pin_i,
   input  logic [NUM_WAKE-1:0] en_i,
   input  logic [NUM_WAKE-1:0] pol_i,
   output logic                evt_o
);
   logic [NUM_WAKE-1:0] act;
   logic [NUM_WAKE-1:0] act_q;

   genvar i;
   for (i = 0; i < NUM_WAKE; i++) begin : g_pin
      logic lvl;
      if (SYNC_STAGES == 0) begin : g_raw
         assign lvl = pin_i[i];
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh <= '0;
            else        sh <= (sh << 1) | SYNC_STAGES'(pin_i[i]);
         end
         assign lvl = sh[SYNC_STAGES-1];
      end
      assign act[i] = pol_i[i] ? ~lvl : lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_q <= '1;
      else        act_q <= act;
   end

   assign evt_o = |(act & ~act_q & en_i);

   // R10
   wake_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i == '0) |-> !evt_o);
endmodule

// File: rtl/rtc_pwr_wake_ctrl.sv
module rtc_pwr_wake_ctrl
   import rpw_pkg::*;
#(
   parameter int NUM_WAKE    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int FLD_W       = 8,
   parameter int N_FLD       = 6
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_wr,
   input  logic [31:0]            cfg_wdata,
   output logic [31:0]            cfg_rdata,
   input  logic                   sec_tick,
   input  logic [FLD_W*N_FLD-1:0] now_bcd,
   input  logic [FLD_W*N_FLD-1:0] alm2_bcd,
   input  logic                   alm2_ie,
   input  logic                   alm2_clr,
   input  logic                   alm1_fire,
   input  logic [NUM_WAKE-1:0]    wake_pin,
   output logic                   pwr_en,
   output logic                   alm2_flag,
   output logic                   alm2_irq
);
   if (NUM_WAKE < 1 || NUM_WAKE > WAKE_MAX) begin : g_bad_wake
      $error("NUM_WAKE must be within 1..4");
   end
   if (FLD_W < 4 || N_FLD < 1) begin : g_bad_fld
      $error("field geometry out of range");
   end

   logic [NUM_WAKE-1:0] wen, wpol;
   logic                pctl, hit, wake_evt, on_req;
   pwr_state_e          pwr_q;
   logic                flag_q;

   rpw_cfg_reg #(.NUM_WAKE(NUM_WAKE)) cfg_i (
      .clk(clk), .rst_n(rst_n), .wr_i(cfg_wr), .wdata_i(cfg_wdata),
      .cfg_o(cfg_rdata), .en_o(wen), .pol_o(wpol), .pctl_o(pctl));

   rpw_alarm_cmp #(.FLD_W(FLD_W), .N_FLD(N_FLD)) cmp_i (
      .clk(clk), .rst_n(rst_n), .tick_i(sec_tick),
      .now_i(now_bcd), .alm_i(alm2_bcd), .hit_o(hit));

   rpw_wake_det #(.NUM_WAKE(NUM_WAKE), .SYNC_STAGES(SYNC_STAGES)) wake_i (
      .clk(clk), .rst_n(rst_n), .pin_i(wake_pin),
      .en_i(wen), .pol_i(wpol), .evt_o(wake_evt));

   assign on_req = wake_evt | alm1_fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             pwr_q <= PWR_ON;
      else if (on_req)        pwr_q <= PWR_ON;
      else if (hit && pctl)   pwr_q <= PWR_OFF;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        flag_q <= 1'b0;
      else if (hit)      flag_q <= 1'b1;
      else if (alm2_clr) flag_q <= 1'b0;
   end

   assign pwr_en    = (pwr_q == PWR_ON);
   assign alm2_flag = flag_q;
   assign alm2_irq  = flag_q & alm2_ie;

   // R3
   flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> alm2_flag);
   // R5
   flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (alm2_clr && !hit) |=> !alm2_flag);
   // R7
   pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && pctl && !on_req) |=> !pwr_en);
   // R12
   pwr_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
      on_req |=> pwr_en);
   // R8
   pwr_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwr_en) |-> $past(on_req));
endmodule

// File: tb/rtc_pwr_wake_ctrl_tb.sv
module rtc_pwr_wake_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        sec_tick = 1'b0;
   logic [47:0] now_bcd = '0;
   logic [47:0] alm2_bcd = '0;
   logic        alm2_ie = 1'b0;
   logic        alm2_clr = 1'b0;
   logic        alm1_fire = 1'b0;
   logic [3:0]  wake_pin = 4'hF;
   logic        pwr_en, alm2_flag, alm2_irq;
   int          total = 0;
   int          bad = 0;
   bit          done = 1'b0;

   localparam logic [47:0] T0 = 48'h25_12_31_23_59_59;

   // {now, alarm, tick, expected flag}
   localparam logic [97:0] VEC [6] = '{
      {48'h25_12_31_23_59_59, 48'h25_12_31_23_59_59, 1'b1, 1'b1},
      {48'h25_12_31_23_59_59, 48'h25_12_31_23_59_59, 1'b0, 1'b0},
      {48'h25_12_31_23_59_58, 48'h25_12_31_23_59_59, 1'b1, 1'b0},
      {48'h26_12_31_23_59_59, 48'h25_12_31_23_59_59, 1'b1, 1'b0},
      {48'h25_12_31_13_59_59, 48'h25_12_31_23_59_59, 1'b1, 1'b0},
      {48'h24_02_29_00_00_00, 48'h24_02_29_00_00_00, 1'b1, 1'b1}
   };

   always #4 clk = ~clk;

   rtc_pwr_wake_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .sec_tick(sec_tick), .now_bcd(now_bcd),
      .alm2_bcd(alm2_bcd), .alm2_ie(alm2_ie), .alm2_clr(alm2_clr),
      .alm1_fire(alm1_fire), .wake_pin(wake_pin), .pwr_en(pwr_en),
      .alm2_flag(alm2_flag), .alm2_irq(alm2_irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr_cfg(input logic [31:0] v);
      @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
      @(negedge clk); cfg_wr = 1'b0;
   endtask

   // returns one negedge after the tick edge: the hit is registered
   task automatic tick_at(input logic [47:0] n, input logic [47:0] a, input logic t);
      @(negedge clk); now_bcd = n; alm2_bcd = a; sec_tick = t;
      @(negedge clk); sec_tick = 1'b0;
   endtask

   task automatic clr_flag();
      @(negedge clk); alm2_clr = 1'b1;
      @(negedge clk); alm2_clr = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 pwr_en", 32'(pwr_en), 32'd1);
      chk("R1 flag", 32'(alm2_flag), 32'd0);
      chk("R1 irq", 32'(alm2_irq), 32'd0);
      chk("R1 cfg", cfg_rdata, 32'h0000_00F0);

      wr_cfg(32'hFFFF_FFFF);
      chk("R2 writable mask", cfg_rdata, 32'h0001_00FF);
      wr_cfg(32'h0000_00F0);
      chk("R2 rewrite", cfg_rdata, 32'h0000_00F0);

      // R3 R4 vector table, alarm power control off
      for (int v = 0; v < 6; v++) begin
         tick_at(VEC[v][97:50], VEC[v][49:2], VEC[v][1]);
         @(negedge clk);
         chk(VEC[v][0] ? "R3 match" : "R4 no match", 32'(alm2_flag), 32'(VEC[v][0]));
         chk("R7 bit16 clear keeps power", 32'(pwr_en), 32'd1);
         clr_flag();
         chk("R5 cleared", 32'(alm2_flag), 32'd0);
      end

      // R6 irq gating
      tick_at(T0, T0, 1'b1); @(negedge clk);
      chk("R6 irq masked", 32'(alm2_irq), 32'd0);
      alm2_ie = 1'b1; #1;
      chk("R6 irq enabled", 32'(alm2_irq), 32'd1);
      clr_flag();
      chk("R6 irq after clear", 32'(alm2_irq), 32'd0);
      alm2_ie = 1'b0;

      // R5 set wins over clear
      tick_at(T0, T0, 1'b1);
      alm2_clr = 1'b1;
      @(negedge clk); alm2_clr = 1'b0;
      chk("R5 set beats clear", 32'(alm2_flag), 32'd1);
      clr_flag();

      // R7 power off, R8 active-low wake on pin0
      wr_cfg(32'h0001_00F1);
      tick_at(T0, T0, 1'b1); @(negedge clk);
      chk("R7 power off", 32'(pwr_en), 32'd0);
      wake_pin = 4'b1110;
      @(negedge clk); @(negedge clk);
      chk("R8 not yet", 32'(pwr_en), 32'd0);
      @(negedge clk);
      chk("R8 active-low wake", 32'(pwr_en), 32'd1);

      // R10 held level and disabled pin
      tick_at(T0, T0, 1'b1); @(negedge clk);
      repeat (5) @(negedge clk);
      chk("R10 held level no wake", 32'(pwr_en), 32'd0);
      wake_pin = 4'b1100;
      repeat (5) @(negedge clk);
      chk("R10 disabled pin ignored", 32'(pwr_en), 32'd0);

      // R9 active-high pin2
      wake_pin = 4'b1001;
      repeat (4) @(negedge clk);
      wr_cfg(32'h0001_00B5);
      repeat (3) @(negedge clk);
      chk("R9 polarity change no wake", 32'(pwr_en), 32'd0);
      wake_pin = 4'b1101;
      @(negedge clk); @(negedge clk);
      chk("R9 not yet", 32'(pwr_en), 32'd0);
      @(negedge clk);
      chk("R9 active-high wake", 32'(pwr_en), 32'd1);

      // R11 primary alarm
      tick_at(T0, T0, 1'b1); @(negedge clk);
      chk("R11 off first", 32'(pwr_en), 32'd0);
      alm1_fire = 1'b1;
      @(negedge clk); alm1_fire = 1'b0;
      chk("R11 alarm1 restores", 32'(pwr_en), 32'd1);

      // R12 simultaneous off and on
      tick_at(T0, T0, 1'b1);
      alm1_fire = 1'b1;
      @(negedge clk); alm1_fire = 1'b0;
      chk("R12 on wins", 32'(pwr_en), 32'd1);
      @(negedge clk);
      chk("R12 stays on", 32'(pwr_en), 32'd1);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule